// File: doc/BRIEF.md
# Two-Sub-Phase Request Parity Checker

This block watches a shared request bus on which every request occupies two consecutive clocks. On the first clock the address lines carry the transaction address. On the second clock the same lines carry transaction-type information. A 5-bit request-type field travels beside the address on both clocks. All bus signals are active-low. Two parity lines belong to each sub-phase and arrive one clock after that sub-phase's data.

The block has two modes. In generator mode it computes the two parity bits for each captured sub-phase and drives them one clock later. In checker mode it compares the parity bits it receives against the parity it computes. It reports which parity bit failed and in which sub-phase, and it raises a single-cycle error pulse. Error recovery is left to the logic that consumes the error outputs.

The two parity bits cover two address groups: an upper group and a lower group, which also takes in the request-type field. The assignment of parity bits to these groups swaps from sub-phase 1 to sub-phase 2. Each parity bit is set by the number of its covered lines that sit electrically low.

Top module: `req_parity_checker`

## Requirements
- R1: A synchronous active-low reset clears all captured state. On the clock after `rst_n` is sampled low, and for as long as it stays low, `err_bits` is 0, `err_phase` is 0, `err_pulse` is 0, `par_out_n` is 2'b11 and `par_out_en` is 0.
- R2: A clock edge that samples `strobe_n` low, while no sub-phase 1 is held, captures `addr_n` and `req_n` as sub-phase 1. The next edge captures the bus as sub-phase 2. `addr_n[k]` carries address bit k+3.
- R3: A parity bit is computed from the electrical levels of the lines it covers. It is 1 when an even number of those lines are low and 0 when an odd number are low, so a group with all lines high gives 1.
- R4: In sub-phase 1, parity bit 0 covers `addr_n[36:21]` (address bits 39 to 24). Parity bit 1 covers `addr_n[20:0]` together with `req_n[4:0]`.
- R5: In sub-phase 2 the coverage swaps. Parity bit 1 covers `addr_n[36:21]`, and parity bit 0 covers `addr_n[20:0]` together with `req_n[4:0]`.
- R6: In checker mode (`gen_mode`=0), the received parity for a sub-phase is sampled one clock after that sub-phase's data. On the following clock, bit i of `err_bits` is 1 exactly when received bit i differs from the computed bit i. `err_phase` then shows 0 for sub-phase 1 and 1 for sub-phase 2.
- R7: `err_pulse` is high for one clock exactly when `err_bits` is nonzero. This happens only in the clock after a check. With no check, `err_bits`, `err_phase` and `err_pulse` are 0.
- R8: In generator mode (`gen_mode`=1), `par_out_n` carries the computed parity of each sub-phase on the clock after that sub-phase's data is driven, and `par_out_en` is 1 with it. No error is reported in this mode. Otherwise `par_out_n` is 2'b11 and `par_out_en` is 0.
- R9: A strobe sampled on the clock right after a sub-phase 2 starts a new request while the previous check completes. Requests with no idle clock between them are each checked correctly.
- R10: A strobe sampled on the sub-phase 2 clock does not start a request. That clock is taken as sub-phase 2 of the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_mode | input | 1 | 1 = generate parity, 0 = check parity |
| strobe_n | input | 1 | Request strobe, active low |
| addr_n | input | 37 | Address / type lines, active low, bit k = address bit k+3 |
| req_n | input | 5 | Request-type lines, active low |
| par_in_n | input | 2 | Received parity lines, one clock after their data |
| par_out_n | output | 2 | Generated parity lines |
| par_out_en | output | 1 | Generated parity is being driven |
| err_bits | output | 2 | Per-parity-bit mismatch |
| err_phase | output | 1 | Sub-phase of the reported check, 0 = first, 1 = second |
| err_pulse | output | 1 | Single-cycle parity error indication |

## Verification
A corrupted phase tracker appears within two clocks. It shows as a wrong `err_phase`, or as a swapped parity-bit coverage that flags the wrong bit of `err_bits` for a single flipped upper-group line. A lost or extra capture shows as a missing or spurious check the clock after the next parity sample. This happens most visibly when requests follow each other with no gap, or when a strobe lands in sub-phase 2. In generator mode, a wrong group assignment appears on `par_out_n` in the clock after each sub-phase.

// File: rtl/rpc_pkg.sv
// Package: shared types for the request parity checker.
// Assumes: a request always spans exactly two sub-phases.
package rpc_pkg;
    typedef enum logic {
        PH_ONE = 1'b0,
        PH_TWO = 1'b1
    } phase_e;
endpackage

// File: rtl/rpc_capture.sv
// Module: rpc_capture
// Samples the bus on the strobe clock (sub-phase 1) and unconditionally on
// the following clock (sub-phase 2). A strobe during sub-phase 2 is not a
// new request. Assumes the bus levels are stable around the clock edge.
module rpc_capture
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 37,
    parameter int REQ_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    output logic              cap_vld,
    output phase_e            cap_phase,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [REQ_W-1:0]  cap_req
);
    logic in_first;

    assign in_first = cap_vld && (cap_phase == PH_ONE);

    // Capture sub-phase data and track which sub-phase is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld   <= 1'b0;
            cap_phase <= PH_ONE;
            cap_addr  <= '1;
            cap_req   <= '1;
        end else if (in_first) begin
            cap_vld   <= 1'b1;
            cap_phase <= PH_TWO;
            cap_addr  <= addr_n;
            cap_req   <= req_n;
        end else if (!strobe_n) begin
            cap_vld   <= 1'b1;
            cap_phase <= PH_ONE;
            cap_addr  <= addr_n;
            cap_req   <= req_n;
        end else begin
            cap_vld   <= 1'b0;
            cap_phase <= PH_ONE;
        end
    end

    // R2
    strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !in_first) |=> (cap_vld && cap_phase == PH_ONE && cap_addr == $past(addr_n)));
    // R10
    second_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_first |=> (cap_vld && cap_phase == PH_TWO && cap_req == $past(req_n)));
    // R9
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && cap_phase == PH_TWO && !strobe_n) |=> (cap_vld && cap_phase == PH_ONE));
endmodule

// File: rtl/rpc_parity_calc.sv
// Module: rpc_parity_calc
// Combinational parity of the two line groups. The result is 1 when an even
// number of covered lines are low. Parity bit to group mapping swaps between
// sub-phases. Assumes HI_W upper address lines form the first group.
module rpc_parity_calc
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 37,
    parameter int REQ_W  = 5,
    parameter int HI_W   = 16
) (
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  phase_e            phase,
    output logic [1:0]        exp_par
);
    localparam int LO_W = ADDR_W - HI_W + REQ_W;

    logic [HI_W-1:0] hi_grp;
    logic [LO_W-1:0] lo_grp;
    logic            hi_level;
    logic            lo_level;

    assign hi_grp = addr_n[ADDR_W-1:ADDR_W-HI_W];
    assign lo_grp = {addr_n[ADDR_W-HI_W-1:0], req_n};

    // Even count of low lines gives a high level.
    assign hi_level = ~(^(~hi_grp));
    assign lo_level = ~(^(~lo_grp));

    // Route each parity bit to its group for the current sub-phase.
    for (genvar i = 0; i < 2; i++) begin : g_bit
        localparam bit HI_IN_FIRST = (i == 0);
        always_comb begin
            if ((phase == PH_ONE) == HI_IN_FIRST) begin
                exp_par[i] = hi_level;
            end else begin
                exp_par[i] = lo_level;
            end
        end
    end

    // R3
    all_high_chk: assert final ((addr_n != '1) || (req_n != '1) || (exp_par == 2'b11));
endmodule

// File: rtl/rpc_outstage.sv
// Module: rpc_outstage
// Registers the result for each captured sub-phase on the clock after its
// data. In generator mode it drives parity. In checker mode it compares
// received parity and reports errors. Assumes par_in_n lags its data by one clock.
module rpc_outstage
    import rpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen_mode,
    input  logic       cap_vld,
    input  phase_e     cap_phase,
    input  logic [1:0] exp_par,
    input  logic [1:0] par_in_n,
    output logic [1:0] par_out_n,
    output logic       par_out_en,
    output logic [1:0] err_bits,
    output logic       err_phase,
    output logic       err_pulse
);
    logic [1:0] mismatch;

    // Per-bit compare of received against computed parity.
    for (genvar i = 0; i < 2; i++) begin : g_cmp
        assign mismatch[i] = exp_par[i] ^ par_in_n[i];
    end

    // Generate or check the held sub-phase, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out_n  <= 2'b11;
            par_out_en <= 1'b0;
            err_bits   <= 2'b00;
            err_phase  <= 1'b0;
            err_pulse  <= 1'b0;
        end else if (cap_vld && gen_mode) begin
            par_out_n  <= exp_par;
            par_out_en <= 1'b1;
            err_bits   <= 2'b00;
            err_phase  <= 1'b0;
            err_pulse  <= 1'b0;
        end else if (cap_vld) begin
            par_out_n  <= 2'b11;
            par_out_en <= 1'b0;
            err_bits   <= mismatch;
            err_phase  <= (cap_phase == PH_TWO);
            err_pulse  <= |mismatch;
        end else begin
            par_out_n  <= 2'b11;
            par_out_en <= 1'b0;
            err_bits   <= 2'b00;
            err_phase  <= 1'b0;
            err_pulse  <= 1'b0;
        end
    end

    // R7
    pulse_matches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == (err_bits != 2'b00));
    // R7
    pulse_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld == 1'b0) |=> (err_pulse == 1'b0 && err_phase == 1'b0));
    // R8
    gen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_out_en |-> (err_bits == 2'b00));
    // R8
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_out_en |-> (par_out_n == 2'b11));
endmodule

// File: rtl/req_parity_checker.sv
// Module: req_parity_checker (top)
// Two-sub-phase request bus parity generator and checker. Captures both
// sub-phases on a strobe and computes the swapped-coverage parity. It then
// drives parity or flags mismatches one clock after each parity sample.
// Assumes all bus lines are active-low and synchronous to clk.
module req_parity_checker
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 37,
    parameter int REQ_W  = 5,
    parameter int HI_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_mode,
    input  logic              strobe_n,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic [1:0]        par_in_n,
    output logic [1:0]        par_out_n,
    output logic              par_out_en,
    output logic [1:0]        err_bits,
    output logic              err_phase,
    output logic              err_pulse
);
    logic              cap_vld;
    phase_e            cap_phase;
    logic [ADDR_W-1:0] cap_addr;
    logic [REQ_W-1:0]  cap_req;
    logic [1:0]        exp_par;

    rpc_capture #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .addr_n   (addr_n),
        .req_n    (req_n),
        .cap_vld  (cap_vld),
        .cap_phase(cap_phase),
        .cap_addr (cap_addr),
        .cap_req  (cap_req)
    );

    rpc_parity_calc #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_calc (
        .addr_n (cap_addr),
        .req_n  (cap_req),
        .phase  (cap_phase),
        .exp_par(exp_par)
    );

    rpc_outstage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_mode  (gen_mode),
        .cap_vld   (cap_vld),
        .cap_phase (cap_phase),
        .exp_par   (exp_par),
        .par_in_n  (par_in_n),
        .par_out_n (par_out_n),
        .par_out_en(par_out_en),
        .err_bits  (err_bits),
        .err_phase (err_phase),
        .err_pulse (err_pulse)
    );

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!err_pulse && !par_out_en && err_bits == 2'b00 && par_out_n == 2'b11));
    // R6
    second_phase_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && cap_phase == PH_TWO && !gen_mode) |=> (err_phase == 1'b1));
endmodule

// File: tb/req_parity_checker_bench.sv
module req_parity_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_mode = 1'b0;
    logic        strobe_n = 1'b1;
    logic [36:0] addr_n = '1;
    logic [4:0]  req_n = '1;
    logic [1:0]  par_in_n = 2'b11;
    logic [1:0]  par_out_n;
    logic        par_out_en;
    logic [1:0]  err_bits;
    logic        err_phase;
    logic        err_pulse;

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    started = 1'b0;

    always #4 clk = ~clk;

    req_parity_checker u_req_parity_checker (
        .clk(clk), .rst_n(rst_n), .gen_mode(gen_mode), .strobe_n(strobe_n),
        .addr_n(addr_n), .req_n(req_n), .par_in_n(par_in_n),
        .par_out_n(par_out_n), .par_out_en(par_out_en), .err_bits(err_bits),
        .err_phase(err_phase), .err_pulse(err_pulse)
    );

    // Level of a group: 1 when an even number of its lines are low.
    function automatic logic grp_level(input logic [36:0] a, input logic [4:0] r, input bit upper);
        int zeros = 0;
        if (upper) begin
            for (int k = 21; k <= 36; k++) if (a[k] == 1'b0) zeros++;
        end else begin
            for (int k = 0; k <= 20; k++) if (a[k] == 1'b0) zeros++;
            for (int k = 0; k <= 4; k++) if (r[k] == 1'b0) zeros++;
        end
        return (zeros % 2 == 0);
    endfunction

    // Parity pair for a sub-phase: ph 0 puts upper on bit 0, ph 1 on bit 1.
    function automatic logic [1:0] bench_par(input logic [36:0] a, input logic [4:0] r, input int ph);
        logic u = grp_level(a, r, 1'b1);
        logic l = grp_level(a, r, 1'b0);
        return (ph == 0) ? {l, u} : {u, l};
    endfunction

    // Reference model state.
    bit          m_pend = 0;
    int          m_ph = 0;
    logic [36:0] m_a;
    logic [4:0]  m_r;
    logic [1:0]  m_err = 0, m_pout = 2'b11;
    logic        m_phase = 0, m_pulse = 0, m_pen = 0;

    always @(posedge clk) begin
        logic [1:0] p;
        if (!rst_n) begin
            m_pend = 0; m_err = 0; m_pout = 2'b11; m_phase = 0; m_pulse = 0; m_pen = 0;
        end else begin
            m_err = 0; m_pout = 2'b11; m_phase = 0; m_pulse = 0; m_pen = 0;
            if (m_pend) begin
                p = bench_par(m_a, m_r, m_ph);
                if (gen_mode) begin
                    m_pout = p; m_pen = 1;
                end else begin
                    m_err = p ^ par_in_n; m_phase = (m_ph == 1); m_pulse = (m_err != 0);
                end
            end
            if (m_pend && m_ph == 0) begin
                m_pend = 1; m_ph = 1; m_a = addr_n; m_r = req_n;
            end else if (!strobe_n) begin
                m_pend = 1; m_ph = 0; m_a = addr_n; m_r = req_n;
            end else begin
                m_pend = 0;
            end
        end
    end

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model between clock edges.
    always @(negedge clk) begin
        if (started) begin
            check("err_bits", {6'd0, err_bits}, {6'd0, m_err});
            check("err_phase", {7'd0, err_phase}, {7'd0, m_phase});
            check("err_pulse", {7'd0, err_pulse}, {7'd0, m_pulse});
            check("par_out_n", {6'd0, par_out_n}, {6'd0, m_pout});
            check("par_out_en", {7'd0, par_out_en}, {7'd0, m_pen});
        end
    end

    // Driver: parity for a cycle's data goes out on the next cycle.
    logic [1:0] nxt_par = 2'b11;
    logic [1:0] nxt_cor = 2'b00;

    task automatic cyc(input logic s, input logic [36:0] a, input logic [4:0] r,
                       input int ph, input logic [1:0] cor);
        @(negedge clk);
        par_in_n = nxt_par ^ nxt_cor;
        strobe_n = s; addr_n = a; req_n = r;
        nxt_par = (ph >= 0) ? bench_par(a, r, ph) : 2'b11;
        nxt_cor = cor;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, {$urandom, $urandom} , 5'($urandom), -1, 2'b00);
    endtask

    task automatic req(input logic [36:0] a1, input logic [4:0] r1, input logic [1:0] c1,
                       input logic [36:0] a2, input logic [4:0] r2, input logic [1:0] c2);
        cyc(1'b0, a1, r1, 0, c1);
        cyc(1'b1, a2, r2, 1, c2);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset with strobe asserted.
        tag = "R1";
        cyc(1'b0, '0, '0, -1, 2'b00);
        started = 1'b1;
        cyc(1'b0, '0, '0, -1, 2'b00);
        cyc(1'b0, '0, '0, -1, 2'b00);
        rst_n = 1'b1;
        cyc(1'b1, '1, '1, -1, 2'b00);
        idle(3);

        // R3 / R2: all-high and random requests with correct parity.
        tag = "R3";
        req('1, '1, 2'b00, '1, '1, 2'b00);
        idle(2);
        tag = "R2";
        for (int i = 0; i < 20; i++) begin
            req({$urandom, $urandom}, 5'($urandom), 2'b00, {$urandom, $urandom}, 5'($urandom), 2'b00);
            idle(1 + (i % 3));
        end

        // R4: flipped upper-group line in sub-phase 1 flags bit 0 only.
        tag = "R4";
        for (int i = 0; i < 6; i++) begin
            req({$urandom, $urandom}, 5'($urandom), 2'b01, '1, '1, 2'b00);
            idle(2);
            req({$urandom, $urandom}, 5'($urandom), 2'b10, '1, '1, 2'b00);
            idle(2);
        end

        // R5: sub-phase 2 coverage swapped.
        tag = "R5";
        for (int i = 0; i < 6; i++) begin
            req('1, '1, 2'b00, {$urandom, $urandom}, 5'($urandom), 2'b10);
            idle(2);
            req('1, '1, 2'b00, {$urandom, $urandom}, 5'($urandom), 2'b01);
            idle(2);
        end

        // R6 / R7: both bits wrong, and random corruption.
        tag = "R6";
        req({$urandom, $urandom}, 5'($urandom), 2'b11, {$urandom, $urandom}, 5'($urandom), 2'b11);
        idle(2);
        tag = "R7";
        for (int i = 0; i < 20; i++) begin
            req({$urandom, $urandom}, 5'($urandom), 2'($urandom), {$urandom, $urandom}, 5'($urandom), 2'($urandom));
            idle(i % 2);
        end
        idle(2);

        // R9: requests with no gap.
        tag = "R9";
        for (int i = 0; i < 15; i++)
            req({$urandom, $urandom}, 5'($urandom), 2'($urandom), {$urandom, $urandom}, 5'($urandom), 2'($urandom));
        idle(3);

        // R10: strobe during sub-phase 2 is not a new request.
        tag = "R10";
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, {$urandom, $urandom}, 5'($urandom), 0, 2'b00);
            cyc(1'b0, {$urandom, $urandom}, 5'($urandom), 1, 2'($urandom));
            idle(2);
        end

        // R8: generator mode, received parity is junk.
        tag = "R8";
        gen_mode = 1'b1;
        for (int i = 0; i < 15; i++) begin
            req({$urandom, $urandom}, 5'($urandom), 2'($urandom), {$urandom, $urandom}, 5'($urandom), 2'($urandom));
            idle(i % 2);
        end
        idle(3);
        gen_mode = 1'b0;
        idle(2);

        // R1: reset in the middle of a request.
        tag = "R1";
        cyc(1'b0, {$urandom, $urandom}, 5'($urandom), 0, 2'b11);
        rst_n = 1'b0;
        cyc(1'b1, {$urandom, $urandom}, 5'($urandom), 1, 2'b11);
        rst_n = 1'b1;
        idle(4);

        started = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule